// File: doc/BRIEF.md
# I2C Master Start-Reservation Controller

This block forms the start-generation front end of an I2C master. It synchronizes the SCL and SDA pins and detects START and STOP conditions. From those it keeps a bus-busy flag. It also accepts a one-cycle start request from software.

When the bus is idle, the request produces a START straight away. The block then parks SCL low until software loads an address byte. When another master owns the bus, the request is stored as a reservation instead, and nothing on the bus changes. The next STOP fires the reservation: the block becomes master by itself and produces the START. Only an address written after that point is sent.

The address is shifted out MSB first. Each bit has a programmable SCL low width and a programmable SCL high width. A master-status output reports whether a request won the bus or is still waiting. A gated, single-cycle stop interrupt tells software when to load the address for a reserved transfer. If a released 1 bit reads back as 0, the block reports a lost-arbitration flag and lets go of both lines. A cancel input withdraws a reservation. A release input gives the bus back after a transfer.

Top module: `i2c_rsv_top`

## Requirements
- R1: `bus_busy` is 0 after reset. It becomes 1 on a START, which is SDA falling while SCL is high. It returns to 0 on a STOP, which is SDA rising while SCL is high. Each pin passes through a two-stage synchronizer, so the flag changes on the third rising clock edge after the pin change.
- R2: A `start_req` pulse on an idle bus (`bus_busy`=0) sets `master_flag` on the next edge. The block then pulls SDA low (`sda_oe`=1) with SCL released for `high_cnt`+1 cycles. After that it also pulls SCL low (`scl_oe`=1) and holds that wait state until an address is loaded.
- R3: A `start_req` on a busy bus with `queue_dis`=0 sets `rsv_pending`. In that case `master_flag`, `scl_oe` and `sda_oe` all stay 0.
- R4: With `queue_dis`=1, a `start_req` on a busy bus is ignored. `rsv_pending` and `master_flag` stay 0.
- R5: When a STOP is detected while `rsv_pending`=1, the block clears `rsv_pending` and sets `master_flag` on that same edge. It then produces a START exactly as in R2.
- R6: `addr_wr` loads `addr_data` only while the block is master and has not yet started shifting. Writes made while idle or while reserved are discarded. A loaded byte is sent MSB first. Each bit is placed on SDA while SCL is pulled low for `low_cnt`+1 cycles, followed by `high_cnt`+1 cycles of SCL released.
- R7: The answer to a start request (`master_flag` set, or `rsv_pending` set) appears one cycle after `start_req`. This is well inside the `low_cnt`+`high_cnt`+4 clock settling window that software waits before reading it.
- R8: `stop_irq` is a one-cycle pulse on the edge where a detected STOP reaches `bus_busy`, provided `stop_irq_en`=1. With `stop_irq_en`=0 it never pulses.
- R9: `cancel_req` while `rsv_pending`=1 clears the reservation. A later STOP then starts nothing.
- R10: Suppose that at the end of a high phase the block is releasing SDA for a 1 bit, but the synchronized SDA reads 0. The block then sets `arb_lost`, clears `master_flag` and releases both lines. The next `start_req` clears `arb_lost`.
- R11: After the last address bit, the block holds SCL low, releases SDA and sets `addr_sent`. `bus_release` while master returns it to idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| start_req | input | 1 | One-cycle start request |
| queue_dis | input | 1 | 1 disables reservation on a busy bus |
| cancel_req | input | 1 | Withdraws a pending reservation |
| bus_release | input | 1 | Leaves master mode and frees both lines |
| addr_wr | input | 1 | Address load strobe |
| addr_data | input | AW | Address byte |
| low_cnt | input | CW | SCL low width minus one, in clocks |
| high_cnt | input | CW | SCL high width minus one, in clocks |
| stop_irq_en | input | 1 | Enables the stop interrupt |
| bus_busy | output | 1 | Bus-in-use flag |
| master_flag | output | 1 | Block owns the bus |
| rsv_pending | output | 1 | Reservation waiting for STOP |
| addr_sent | output | 1 | Address fully shifted, SCL held low |
| arb_lost | output | 1 | Arbitration lost on an address bit |
| stop_irq | output | 1 | Stop-detect interrupt pulse |

## Verification
The assertions take some things about the inputs for granted. `start_req` and `cancel_req` never pulse in the same cycle. Another master never stretches SCL while this block owns the bus. Its only interference is holding SDA low, and it does that only while SCL is low. `high_cnt` is assumed to be at least 2, so the synchronized SDA settles before the arbitration sample.

The stimulus keeps within these limits. The emulated foreign master changes only SDA, always with SCL high, and only when this block is not driving. In the arbitration case it pulls SDA low during the wait state, before the first bit.

// File: rtl/i2c_rsv_pkg.sv
package i2c_rsv_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RSV,
      ST_STA,
      ST_HOLD,
      ST_BLO,
      ST_BHI,
      ST_DONE
   } seq_state_t;

   function automatic logic owns_bus(seq_state_t s);
      return (s == ST_STA) || (s == ST_HOLD) || (s == ST_BLO) ||
             (s == ST_BHI) || (s == ST_DONE);
   endfunction

   function automatic logic scl_pulled(seq_state_t s);
      return (s == ST_HOLD) || (s == ST_BLO) || (s == ST_DONE);
   endfunction

endpackage

// File: rtl/i2c_rsv_linemon.sv
module i2c_rsv_linemon #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   input  logic irq_en,
   output logic sda_s,
   output logic stop_det,
   output logic busy,
   output logic stop_irq
);
   logic [STAGES-1:0] scl_q;
   logic [STAGES-1:0] sda_q;
   logic              scl_prev;
   logic              sda_prev;
   logic              scl_s;
   logic              start_det;

   // idle bus reads high, so the chain resets to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= '1;
         sda_q    <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_q    <= {scl_q[STAGES-2:0], scl_raw};
         sda_q    <= {sda_q[STAGES-2:0], sda_raw};
         scl_prev <= scl_q[STAGES-1];
         sda_prev <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         stop_irq <= 1'b0;
      end else begin
         if (start_det)     busy <= 1'b1;
         else if (stop_det) busy <= 1'b0;
         stop_irq <= stop_det & irq_en;
      end
   end
endmodule

// File: rtl/i2c_rsv_timer.sv
module i2c_rsv_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_rsv_seq.sv
module i2c_rsv_seq
   import i2c_rsv_pkg::*;
#(
   parameter int AW     = 8,
   parameter int CW     = 8,
   parameter bit ARB_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          queue_dis,
   input  logic          cancel_req,
   input  logic          bus_release,
   input  logic          addr_wr,
   input  logic [AW-1:0] addr_data,
   input  logic [CW-1:0] low_cnt,
   input  logic [CW-1:0] high_cnt,
   input  logic          busy,
   input  logic          stop_det,
   input  logic          sda_s,
   output logic          scl_oe,
   output logic          sda_oe,
   output logic          master_flag,
   output logic          rsv_pending,
   output logic          addr_sent,
   output logic          arb_lost
);
   localparam int BW = (AW > 1) ? $clog2(AW) : 1;
   localparam logic [BW-1:0] LAST_BIT = BW'(AW - 1);

   seq_state_t    state, nstate;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_zero;
   logic [AW-1:0] shreg;
   logic          addr_valid;
   logic [BW-1:0] bit_cnt;
   logic          lost_now;

   i2c_rsv_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   generate
      if (ARB_EN) begin : g_arb
         assign lost_now = shreg[AW-1] & ~sda_s;
      end else begin : g_no_arb
         assign lost_now = 1'b0;
      end
   endgenerate

   always_comb begin
      nstate   = state;
      tmr_load = 1'b0;
      tmr_val  = high_cnt;
      unique case (state)
         ST_IDLE: if (start_req) begin
            if (!busy) begin
               nstate   = ST_STA;
               tmr_load = 1'b1;
            end else if (!queue_dis) begin
               nstate = ST_RSV;
            end
         end
         ST_RSV: begin
            if (cancel_req) nstate = ST_IDLE;
            else if (stop_det) begin
               nstate   = ST_STA;
               tmr_load = 1'b1;
            end
         end
         ST_STA: if (tmr_zero) nstate = ST_HOLD;
         ST_HOLD: if (addr_valid) begin
            nstate   = ST_BLO;
            tmr_load = 1'b1;
            tmr_val  = low_cnt;
         end
         ST_BLO: if (tmr_zero) begin
            nstate   = ST_BHI;
            tmr_load = 1'b1;
         end
         ST_BHI: if (tmr_zero) begin
            if (lost_now)                nstate = ST_IDLE;
            else if (bit_cnt == LAST_BIT) nstate = ST_DONE;
            else begin
               nstate   = ST_BLO;
               tmr_load = 1'b1;
               tmr_val  = low_cnt;
            end
         end
         ST_DONE: nstate = ST_DONE;
         default: nstate = ST_IDLE;
      endcase
      if (bus_release && owns_bus(state)) nstate = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         shreg      <= '0;
         addr_valid <= 1'b0;
         bit_cnt    <= '0;
         arb_lost   <= 1'b0;
      end else begin
         state <= nstate;
         if (state == ST_HOLD && nstate == ST_BLO) begin
            addr_valid <= 1'b0;
            bit_cnt    <= '0;
         end else if (state == ST_BHI && nstate == ST_BLO) begin
            shreg   <= {shreg[AW-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
         end else if (addr_wr && (state == ST_STA || state == ST_HOLD)) begin
            shreg      <= addr_data;
            addr_valid <= 1'b1;
         end
         if (nstate == ST_IDLE) addr_valid <= 1'b0;
         if (state == ST_BHI && tmr_zero && lost_now) arb_lost <= 1'b1;
         else if (start_req)                          arb_lost <= 1'b0;
      end
   end

   always_comb begin
      scl_oe = scl_pulled(state);
      unique case (state)
         ST_STA, ST_HOLD: sda_oe = 1'b1;
         ST_BLO, ST_BHI:  sda_oe = ~shreg[AW-1];
         default:         sda_oe = 1'b0;
      endcase
   end

   assign master_flag = owns_bus(state);
   assign rsv_pending = (state == ST_RSV);
   assign addr_sent   = (state == ST_DONE);
endmodule

// File: rtl/i2c_rsv_top.sv
module i2c_rsv_top #(
   parameter int AW          = 8,
   parameter int CW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ARB_EN      = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_in,
   input  logic          sda_in,
   output logic          scl_oe,
   output logic          sda_oe,
   input  logic          start_req,
   input  logic          queue_dis,
   input  logic          cancel_req,
   input  logic          bus_release,
   input  logic          addr_wr,
   input  logic [AW-1:0] addr_data,
   input  logic [CW-1:0] low_cnt,
   input  logic [CW-1:0] high_cnt,
   input  logic          stop_irq_en,
   output logic          bus_busy,
   output logic          master_flag,
   output logic          rsv_pending,
   output logic          addr_sent,
   output logic          arb_lost,
   output logic          stop_irq
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("i2c_rsv_top: AW must be at least 2");
      end
      if (CW < 2) begin : g_bad_cw
         $error("i2c_rsv_top: CW must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_rsv_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic sda_s;
   logic stop_det;

   i2c_rsv_linemon #(.STAGES(SYNC_STAGES)) u_linemon (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_raw  (scl_in),
      .sda_raw  (sda_in),
      .irq_en   (stop_irq_en),
      .sda_s    (sda_s),
      .stop_det (stop_det),
      .busy     (bus_busy),
      .stop_irq (stop_irq)
   );

   i2c_rsv_seq #(.AW(AW), .CW(CW), .ARB_EN(ARB_EN)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_req   (start_req),
      .queue_dis   (queue_dis),
      .cancel_req  (cancel_req),
      .bus_release (bus_release),
      .addr_wr     (addr_wr),
      .addr_data   (addr_data),
      .low_cnt     (low_cnt),
      .high_cnt    (high_cnt),
      .busy        (bus_busy),
      .stop_det    (stop_det),
      .sda_s       (sda_s),
      .scl_oe      (scl_oe),
      .sda_oe      (sda_oe),
      .master_flag (master_flag),
      .rsv_pending (rsv_pending),
      .addr_sent   (addr_sent),
      .arb_lost    (arb_lost)
   );
endmodule

// File: rtl/i2c_rsv_chk.sv
module i2c_rsv_chk (
   input logic clk,
   input logic rst_n,
   input logic start_req,
   input logic queue_dis,
   input logic cancel_req,
   input logic bus_busy,
   input logic master_flag,
   input logic rsv_pending,
   input logic scl_oe,
   input logic sda_oe,
   input logic arb_lost,
   input logic stop_irq,
   input logic stop_irq_en
);
   assert_lines_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe || sda_oe) |-> master_flag);

   assert_rsv_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_pending |-> (!master_flag && !scl_oe && !sda_oe));

   assert_queue_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsv_pending) |-> $past(start_req && bus_busy && !queue_dis));

   assert_auto_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(master_flag) |-> ($past(start_req) || $past(rsv_pending)));

   assert_fast_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !bus_busy && !master_flag && !rsv_pending) |=> master_flag);

   assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_irq |=> !stop_irq);

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_irq |-> $past(stop_irq_en));

   assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_req && rsv_pending) |=> !rsv_pending);

   assert_arb_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> (!master_flag && !scl_oe && !sda_oe));
endmodule

bind i2c_rsv_top i2c_rsv_chk u_chk (.*);

// File: tb/i2c_rsv_top_bench.sv
module i2c_rsv_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 8;
   localparam int CW    = 8;
   localparam int LOWV  = 4;
   localparam int HIGHV = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_scl = 1'b1, ext_sda = 1'b1;
   logic scl_oe, sda_oe;
   logic start_req = 0, queue_dis = 0, cancel_req = 0, bus_release = 0;
   logic addr_wr = 0;
   logic [AW-1:0] addr_data = '0;
   logic [CW-1:0] low_cnt = CW'(LOWV), high_cnt = CW'(HIGHV);
   logic stop_irq_en = 1'b1;
   logic bus_busy, master_flag, rsv_pending, addr_sent, arb_lost, stop_irq;

   wire scl_line = ext_scl & ~scl_oe;
   wire sda_line = ext_sda & ~sda_oe;

   i2c_rsv_top u_i2c_rsv_top (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .start_req(start_req),
      .queue_dis(queue_dis), .cancel_req(cancel_req), .bus_release(bus_release),
      .addr_wr(addr_wr), .addr_data(addr_data), .low_cnt(low_cnt),
      .high_cnt(high_cnt), .stop_irq_en(stop_irq_en), .bus_busy(bus_busy),
      .master_flag(master_flag), .rsv_pending(rsv_pending),
      .addr_sent(addr_sent), .arb_lost(arb_lost), .stop_irq(stop_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0, n_bad = 0, irq_cnt = 0, nc = 0;
   int hi_t = 0, lo_t = 0;
   bit hi_seen = 0, lo_seen = 0, mon_en = 0, scl_prev = 1;
   bit exp_q[$];

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: the expected bit stream for one address byte, MSB first
   task automatic push_addr(logic [AW-1:0] a);
      for (int i = AW - 1; i >= 0; i--) exp_q.push_back(a[i]);
   endtask

   task automatic write_addr(logic [AW-1:0] a);
      addr_data = a; addr_wr = 1'b1; tick(1); addr_wr = 1'b0;
   endtask

   task automatic ext_start();
      ext_sda = 1'b0; tick(4);
   endtask

   task automatic ext_stop();
      ext_sda = 1'b1; tick(4);
   endtask

   task automatic wait_sent();
      for (int k = 0; k < 500 && !addr_sent; k++) tick(1);
   endtask

   // monitor: pops expected bits at each SCL rise and measures widths
   always @(negedge clk) begin
      nc++;
      if (stop_irq) irq_cnt++;
      if (mon_en) begin
         if (scl_line && !scl_prev) begin
            if (exp_q.size() == 0) chk("R6 unexpected SCL pulse", 1, 0);
            else chk("R6 address bit", int'(sda_line), int'(exp_q.pop_front()));
            if (lo_seen) chk("R6 SCL low width", nc - lo_t, LOWV + 1);
            hi_t = nc; hi_seen = 1;
         end else if (!scl_line && scl_prev) begin
            if (hi_seen) chk("R6 SCL high width", nc - hi_t, HIGHV + 1);
            lo_t = nc; lo_seen = 1;
         end
      end
      scl_prev = scl_line;
   end

   task automatic run_shift(logic [AW-1:0] a);
      hi_seen = 0; lo_seen = 0; mon_en = 1;
      push_addr(a);
      write_addr(a);
      wait_sent();
      tick(2);
      mon_en = 0;
      chk("R6 all bits seen", exp_q.size(), 0);
      chk("R11 addr_sent", int'(addr_sent), 1);
      chk("R11 SCL held", int'(scl_oe), 1);
      chk("R11 SDA released", int'(sda_oe), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      chk("watchdog", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      tick(3);
      chk("R1 reset busy", int'(bus_busy), 0);
      chk("R2 reset master", int'(master_flag), 0);
      chk("R3 reset pending", int'(rsv_pending), 0);
      chk("R2 reset scl_oe", int'(scl_oe), 0);
      chk("R8 reset irq", int'(stop_irq), 0);
      rst_n = 1'b1;
      tick(2);

      // R1: START and STOP detection latency
      ext_sda = 1'b0; tick(2);
      chk("R1 busy before third edge", int'(bus_busy), 0);
      tick(1);
      chk("R1 busy after START", int'(bus_busy), 1);
      tick(2);
      ext_sda = 1'b1; tick(3);
      chk("R1 free after STOP", int'(bus_busy), 0);
      tick(3);

      // R2/R7: immediate START on idle bus
      start_req = 1'b1; tick(1); start_req = 1'b0;
      chk("R7 master answer", int'(master_flag), 1);
      chk("R2 SDA pulled", int'(sda_oe), 1);
      chk("R2 SCL free", int'(scl_oe), 0);
      tick(HIGHV);
      chk("R2 SCL free at end of START", int'(scl_oe), 0);
      tick(1);
      chk("R2 wait state SCL low", int'(scl_oe), 1);
      tick(10);
      chk("R2 wait state held", int'(scl_oe), 1);
      run_shift(8'hA5);
      bus_release = 1'b1; tick(1); bus_release = 1'b0;
      chk("R11 release master", int'(master_flag), 0);
      chk("R11 release lines", int'(scl_oe | sda_oe), 0);
      tick(4);

      // R4: busy bus, queuing disabled
      queue_dis = 1'b1;
      start_req = 1'b1; tick(1); start_req = 1'b0;
      tick(2);
      chk("R4 no reservation", int'(rsv_pending), 0);
      chk("R4 no master", int'(master_flag), 0);
      queue_dis = 1'b0;

      // R3/R5/R6/R8: reservation fired by STOP
      start_req = 1'b1; tick(1); start_req = 1'b0;
      chk("R7 reservation answer", int'(rsv_pending), 1);
      chk("R3 not master", int'(master_flag), 0);
      chk("R3 lines untouched", int'(scl_oe | sda_oe), 0);
      write_addr(8'h3C);
      ext_start();
      irq_cnt = 0;
      ext_sda = 1'b1; tick(2);
      chk("R5 still pending before stop seen", int'(rsv_pending), 1);
      tick(1);
      chk("R5 auto master", int'(master_flag), 1);
      chk("R5 pending cleared", int'(rsv_pending), 0);
      chk("R8 irq pulse", int'(stop_irq), 1);
      tick(1);
      chk("R8 irq single cycle", int'(stop_irq), 0);
      tick(20);
      chk("R6 early write discarded", int'(addr_sent), 0);
      chk("R6 still in wait", int'(scl_oe & sda_oe), 1);
      chk("R8 irq count", irq_cnt, 1);
      run_shift(8'h5A);
      bus_release = 1'b1; tick(1); bus_release = 1'b0;
      tick(3);

      // R9: cancel a reservation
      start_req = 1'b1; tick(1); start_req = 1'b0;
      chk("R9 pending set", int'(rsv_pending), 1);
      cancel_req = 1'b1; tick(1); cancel_req = 1'b0;
      chk("R9 pending cleared", int'(rsv_pending), 0);
      ext_start(); ext_stop(); tick(4);
      chk("R9 no start after cancel", int'(master_flag), 0);
      chk("R9 lines free", int'(scl_oe | sda_oe), 0);

      // R8: interrupt disabled
      stop_irq_en = 1'b0; irq_cnt = 0;
      ext_start(); ext_stop(); tick(2);
      chk("R8 no irq when disabled", irq_cnt, 0);
      chk("R1 free again", int'(bus_busy), 0);
      stop_irq_en = 1'b1;

      // R10: arbitration lost on first bit
      start_req = 1'b1; tick(1); start_req = 1'b0;
      tick(HIGHV + 3);
      write_addr(8'hFF);
      ext_sda = 1'b0;
      tick(40);
      chk("R10 arb_lost", int'(arb_lost), 1);
      chk("R10 master dropped", int'(master_flag), 0);
      chk("R10 lines released", int'(scl_oe | sda_oe), 0);
      ext_sda = 1'b1; tick(4);
      chk("R1 STOP after arbitration", int'(bus_busy), 0);
      start_req = 1'b1; tick(1); start_req = 1'b0;
      chk("R10 flag cleared", int'(arb_lost), 0);
      chk("R10 new start", int'(master_flag), 1);
      bus_release = 1'b1; tick(1); bus_release = 1'b0;
      tick(6);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule